// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory with a small internal array. Its host interface lets reads and writes follow one another on every clock with no idle cycles between them. Every command is taken on a rising clock edge. A command is either a load, which brings in a new address together with the chip selects and the read/write choice, or an advance, which steps a two-bit burst counter over the low address bits. Read data and write data both travel two enabled clocks behind their address, so the data bus carries one transfer per cycle whatever the mix of operations.

The data bus is split into an input port and an output port, with a flag that marks the cycle in which read data is valid. Each byte lane has its own active-low write enable. An active-high stall input freezes the whole pipeline by ignoring clock edges. An asynchronous snooze input puts the device in standby: it ignores every other input, keeps the array contents and drops the output flag. When a read follows a write to the same word one cycle later, the array is read while that write is being committed. A forwarding path supplies the new lane values in that case.

Top module: `zbt_sram`

## Requirements
- R1: After reset `rdata_oe` is 0, and a read of any word that has never been written returns 0.
- R2: A read loaded at enabled edge k shows its word on `rdata` with `rdata_oe`=1 after enabled edge k+2. `rdata_oe` is 1 only in cycles whose data comes from a read slot.
- R3: A write loaded at enabled edge k takes `wdata` at enabled edge k+2. Lane i is the bits [8i+7:8i] and is written only when bit i of `lane_we_n` was 0 at edge k. When all bits are 1, no lane is written.
- R4: A load selects the device only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Otherwise the load and every advance that follows it until the next load are idle: they write nothing and keep `rdata_oe` at 0.
- R5: `wr_n` is decoded only on a load (`adv`=0), with 0 meaning write and 1 meaning read. Advance cycles keep the operation latched by the last load whatever `wr_n` is.
- R6: With `adv`=1 the slot address is the loaded address with bits [1:0] replaced by (loaded bits [1:0] + number of advances since the load) mod 4. The upper bits stay unchanged.
- R7: While `stall`=1, clock edges are ignored. No pipeline stage, counter, array word, `rdata` or `rdata_oe` changes, and data timing counts enabled edges only.
- R8: While `snooze`=1, `rdata_oe` is 0 at once, all other inputs are ignored and the array keeps its contents. After release, operation resumes from the frozen state.
- R9: Reads and writes can be issued on consecutive cycles. A read loaded one cycle after a write to the same word returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snooze | input | 1 | Asynchronous standby request, active high |
| stall | input | 1 | Ignore this clock edge when high |
| addr | input | 8 | Word address taken on a load |
| sel_a_n | input | 1 | Active-low chip select, taken on a load |
| sel_b_n | input | 1 | Second active-low chip select, taken on a load |
| sel_c | input | 1 | Active-high chip select, taken on a load |
| wr_n | input | 1 | 0 = write, 1 = read, decoded on a load |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| lane_we_n | input | 4 | Per-lane active-low write enables |
| wdata | input | 32 | Write data bus |
| rdata | output | 32 | Read data bus |
| rdata_oe | output | 1 | High while `rdata` carries valid read data |

## Verification
The assertions assume that `stall` and `snooze` change only between rising edges, so that the value seen at an edge is the value that gated it, and that all inputs are known once reset is released. The bench changes every input on the falling edge and keeps each level for a full cycle. It places write data on the bus in the cycle just before the second enabled edge after its address, and it counts only enabled edges when stall or snooze intervene. A cycle-level reference model in the bench tracks latched operations, burst offsets and lane merges from the requirements. It gives the expected `rdata_oe` and `rdata` for every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int DEF_ADDR_W  = 8;
  localparam int DEF_LANES   = 4;
  localparam int DEF_LANE_W  = 8;
  localparam int DEF_BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int LANES   = DEF_LANES,
  parameter int BURST_W = DEF_BURST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_we_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_be_n
);

  localparam int HI_W = ADDR_W - BURST_W;

  op_e                op_q, op_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] low_d;
  logic [ADDR_W-1:0]  addr_d;
  logic               chip_on;

  always_comb begin
    chip_on = ~sel_a_n & ~sel_b_n & sel_c;
    if (load) begin
      base_d = addr;
      cnt_d  = '0;
      if (!chip_on)   op_d = OP_IDLE;
      else if (wr_n)  op_d = OP_READ;
      else            op_d = OP_WRITE;
    end else begin
      base_d = base_q;
      cnt_d  = cnt_q + 1'b1;
      op_d   = op_q;
    end
    low_d  = base_d[BURST_W-1:0] + cnt_d;
    addr_d = {base_d[ADDR_W-1:BURST_W], low_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be_n <= '1;
    end else if (en) begin
      op_q    <= op_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      s1_op   <= op_d;
      s1_addr <= addr_d;
      s1_be_n <= lane_we_n;
    end
  end

  // R5: an advance keeps the operation type of the slot before it
  p_adv_keeps_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load |=> s1_op == $past(s1_op));

  // R6: an advance steps only the low bits, by one, modulo the group
  p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load |=> (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])) &&
                    (s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + 1'b1)));

  // R4: a deselected burst stays deselected through advances
  p_deselect_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load && (s1_op == OP_IDLE) |=> s1_op == OP_IDLE);

  // R4: a load with any select inactive yields an idle slot
  p_load_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && load && !(~sel_a_n & ~sel_b_n & sel_c) |=> s1_op == OP_IDLE);

  if (HI_W < 1) begin : g_bad_width
    initial $error("zbt_cmd_stage: ADDR_W must exceed BURST_W");
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  op_e                      s1_op,
  input  logic [ADDR_W-1:0]        s1_addr,
  input  logic [LANES-1:0]         s1_be_n,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output op_e                      s2_op,
  output logic [LANES*LANE_W-1:0]  s2_rdata
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be_n;
  logic [DATA_W-1:0] rd_raw;
  logic [DATA_W-1:0] rd_fwd;
  logic              commit;
  logic              same_word;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_comb begin
    commit    = en & (s2_op == OP_WRITE);
    same_word = commit & (s2_addr == s1_addr);
    rd_raw    = mem[s1_addr];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    always_comb begin
      if (same_word && !s2_be_n[g])
        rd_fwd[g*LANE_W +: LANE_W] = wdata[g*LANE_W +: LANE_W];
      else
        rd_fwd[g*LANE_W +: LANE_W] = rd_raw[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!s2_be_n[l]) mem[s2_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op    <= OP_IDLE;
      s2_addr  <= '0;
      s2_be_n  <= '1;
      s2_rdata <= '0;
    end else if (en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_be_n  <= s1_be_n;
      s2_rdata <= rd_fwd;
    end
  end

  // R7: the second stage moves only on enabled edges
  p_stage_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(s2_op) && $stable(s2_addr) && $stable(s2_rdata));

  // R2: the second stage takes the slot of the first on an enabled edge
  p_stage_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> s2_op == $past(s1_op));

endmodule

// File: rtl/zbt_out_reg.sv
module zbt_out_reg
  import zbt_pkg::*;
#(
  parameter int DATA_W = DEF_LANES * DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               s2_op,
  input  logic [DATA_W-1:0] s2_rdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              oe_q
);

  logic              oe_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    oe_d    = (s2_op == OP_READ);
    rdata_d = oe_d ? s2_rdata : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else if (en) begin
      oe_q    <= oe_d;
      rdata_q <= rdata_d;
    end
  end

  // R2: a read slot in stage two drives the bus on the next edge
  p_oe_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (s2_op == OP_READ) |=> oe_q && (rdata_q == $past(s2_rdata)));

  // R2: write and idle slots never raise the flag
  p_oe_not_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (s2_op != OP_READ) |=> !oe_q);

  // R7: outputs hold while edges are ignored
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(oe_q) && $stable(rdata_q));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int LANES   = DEF_LANES,
  parameter int LANE_W  = DEF_LANE_W,
  parameter int BURST_W = DEF_BURST_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snooze,
  input  logic                    stall,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    wr_n,
  input  logic                    adv,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              en;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_be_n;
  op_e               s2_op;
  logic [DATA_W-1:0] s2_rdata;
  logic [DATA_W-1:0] rdata_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_comb begin
    rst_s_n  = rst_pipe[1];
    en       = ~stall & ~snooze;
    rdata    = rdata_q;
    rdata_oe = oe_q & ~snooze;
  end

  zbt_cmd_stage #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BURST_W(BURST_W)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (en),
    .load     (~adv),
    .addr     (addr),
    .sel_a_n  (sel_a_n),
    .sel_b_n  (sel_b_n),
    .sel_c    (sel_c),
    .wr_n     (wr_n),
    .lane_we_n(lane_we_n),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .s1_be_n  (s1_be_n)
  );

  zbt_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (en),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s1_be_n (s1_be_n),
    .wdata   (wdata),
    .s2_op   (s2_op),
    .s2_rdata(s2_rdata)
  );

  zbt_out_reg #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (en),
    .s2_op   (s2_op),
    .s2_rdata(s2_rdata),
    .rdata_q (rdata_q),
    .oe_q    (oe_q)
  );

  // R8: during standby neither pipeline stage moves
  p_snooze_freeze_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    snooze |=> $stable(s1_addr) && $stable(s1_op) && $stable(s2_op));

  // R1: the output flag is low while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s_n |-> !rdata_oe);

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              snooze, stall;
  logic [ADDR_W-1:0] addr;
  logic              sel_a_n, sel_b_n, sel_c;
  logic              wr_n, adv;
  logic [LANES-1:0]  lane_we_n;
  logic [DW-1:0]     wdata;
  logic [DW-1:0]     rdata;
  logic              rdata_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit [DW-1:0]     ref_mem [256];
  bit              m_sel, m_wr;
  bit [ADDR_W-1:0] m_base;
  bit [1:0]        m_cnt;
  bit              p1_v, p1_w, p2_v, p2_w;
  bit [ADDR_W-1:0] p1_a, p2_a;
  bit [LANES-1:0]  p1_b, p2_b;
  bit              e_oe;
  bit [DW-1:0]     e_rd;

  always #(CLK_P/2) clk = ~clk;

  zbt_sram dut (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .stall(stall), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .wr_n(wr_n), .adv(adv),
    .lane_we_n(lane_we_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic bit [DW-1:0] merge(bit [DW-1:0] old, bit [DW-1:0] nw, bit [LANES-1:0] ben);
    for (int i = 0; i < LANES; i++) if (!ben[i]) old[i*8 +: 8] = nw[i*8 +: 8];
    return old;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of stimulus; wd is the data for the write loaded two enabled edges earlier
  task automatic cyc(input bit ld, input bit wrn, input bit [7:0] a, input bit [3:0] ben,
                     input bit [2:0] ce, input bit [31:0] wd, input bit stl, input bit snz,
                     input string tag);
    @(negedge clk);
    adv = ~ld; wr_n = wrn; addr = a; lane_we_n = ben;
    {sel_a_n, sel_b_n, sel_c} = ce; wdata = wd; stall = stl; snooze = snz;
    @(posedge clk);
    if (!stl && !snz) begin
      if (p2_v && !p2_w) begin e_rd = ref_mem[p2_a]; e_oe = 1; end
      else e_oe = 0;
      if (p2_v && p2_w) ref_mem[p2_a] = merge(ref_mem[p2_a], wd, p2_b);
      p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_b = p1_b;
      if (ld) begin m_sel = (ce == 3'b001); m_wr = ~wrn; m_base = a; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
      p1_v = m_sel; p1_w = m_wr; p1_a = {m_base[7:2], m_base[1:0] + m_cnt}; p1_b = ben;
    end
    #(CLK_P/4);
    check({tag, " oe"}, {31'd0, rdata_oe}, {31'd0, (snz ? 1'b0 : e_oe)});
    if (!snz && e_oe) check({tag, " data"}, rdata, e_rd);
  endtask

  localparam bit [2:0] SEL = 3'b001;
  localparam bit [2:0] OFF = 3'b110;

  task automatic idle(input bit [31:0] wd, input string tag);
    cyc(1, 1, 8'h00, 4'hF, OFF, wd, 0, 0, tag);
  endtask
  task automatic rd(input bit [7:0] a, input bit [31:0] wd, input string tag);
    cyc(1, 1, a, 4'hF, SEL, wd, 0, 0, tag);
  endtask
  task automatic wr(input bit [7:0] a, input bit [3:0] ben, input bit [31:0] wd, input string tag);
    cyc(1, 0, a, ben, SEL, wd, 0, 0, tag);
  endtask
  task automatic nxt(input bit [3:0] ben, input bit [31:0] wd, input string tag);
    cyc(0, 1, 8'h00, ben, SEL, wd, 0, 0, tag);
  endtask

  task automatic t_reset;
    check("R1 reset oe", {31'd0, rdata_oe}, 32'd0);
    rd(8'h10, 0, "R1 load"); idle(0, "R1"); idle(0, "R1 zero word"); idle(0, "R2 flag drop");
  endtask

  task automatic t_back_to_back;
    wr(8'h20, 4'h0, 0, "R9");
    rd(8'h20, 0, "R9");
    wr(8'h21, 4'h0, 32'hA5A5_0F0F, "R9");
    rd(8'h20, 0, "R9 forward");
    idle(32'h1234_5678, "R9");
    rd(8'h21, 0, "R9");
    idle(0, "R9"); idle(0, "R9 readback"); idle(0, "R9");
  endtask

  task automatic t_lanes;
    wr(8'h40, 4'h0, 0, "R3");
    idle(0, "R3");
    wr(8'h40, 4'b1010, 32'h1122_3344, "R3");
    idle(0, "R3");
    wr(8'h40, 4'hF, 32'hAABB_CCDD, "R3");
    rd(8'h40, 0, "R3");
    idle(32'hFFFF_FFFF, "R3 no lane");
    idle(0, "R3 partial 11BB33DD");
    idle(0, "R3");
  endtask

  task automatic t_burst;
    wr(8'h32, 4'h0, 0, "R6");
    nxt(4'h0, 0, "R6");
    nxt(4'h0, 32'hD000_0032, "R6");
    nxt(4'h0, 32'hD100_0033, "R6");
    idle(32'hD200_0030, "R6");
    idle(32'hD300_0031, "R6");
    rd(8'h33, 0, "R6");
    nxt(4'hF, 0, "R6");
    nxt(4'hF, 0, "R6 wrap 33");
    nxt(4'hF, 0, "R6 wrap 30");
    idle(0, "R6 wrap 31");
    idle(0, "R6 wrap 32");
    idle(0, "R6");
  endtask

  task automatic t_op_hold;
    rd(8'h32, 0, "R5");
    cyc(0, 0, 8'h77, 4'h0, 3'b110, 0, 0, 0, "R5 advance wr_n low");
    idle(32'hDEAD_BEEF, "R5 read slot");
    idle(32'hDEAD_BEEF, "R5 still read");
    rd(8'h33, 0, "R5"); idle(0, "R5"); idle(0, "R5 unchanged");
    idle(0, "R5");
  endtask

  task automatic t_chip_sel;
    cyc(1, 0, 8'h50, 4'h0, 3'b101, 0, 0, 0, "R4 a off");
    cyc(0, 0, 8'h00, 4'h0, SEL, 0, 0, 0, "R4 adv");
    cyc(1, 0, 8'h52, 4'h0, 3'b011, 32'hBAD0_0001, 0, 0, "R4 b off");
    cyc(1, 0, 8'h53, 4'h0, 3'b000, 32'hBAD0_0002, 0, 0, "R4 c off");
    cyc(1, 1, 8'h50, 4'h0, 3'b000, 32'hBAD0_0003, 0, 0, "R4 read off");
    cyc(0, 1, 8'h00, 4'h0, SEL, 32'hBAD0_0004, 0, 0, "R4 adv off");
    idle(32'hBAD0_0005, "R4 no flag");
    rd(8'h50, 0, "R4"); nxt(4'hF, 0, "R4"); rd(8'h52, 0, "R4 zero 50");
    rd(8'h53, 0, "R4 zero 51"); idle(0, "R4 zero 52"); idle(0, "R4 zero 53");
    idle(0, "R4");
  endtask

  task automatic t_stall;
    rd(8'h30, 0, "R7");
    cyc(1, 0, 8'h99, 4'h0, SEL, 32'hEEEE_EEEE, 1, 0, "R7 stall");
    cyc(1, 0, 8'h98, 4'h0, SEL, 32'hEEEE_EEEE, 1, 0, "R7 stall");
    nxt(4'hF, 0, "R7");
    cyc(1, 1, 8'h00, 4'hF, SEL, 0, 1, 0, "R7 stall");
    idle(0, "R7 read 30");
    cyc(1, 1, 8'h00, 4'hF, SEL, 0, 1, 0, "R7 hold oe");
    idle(0, "R7 read 31");
    wr(8'h60, 4'h0, 0, "R7");
    cyc(1, 1, 8'h60, 4'h0, SEL, 32'h5555_5555, 1, 0, "R7 stall");
    idle(32'h6666_6666, "R7");
    idle(32'h0F1E_2D3C, "R7 data edge");
    rd(8'h60, 0, "R7"); idle(0, "R7"); idle(0, "R7 written 60");
    idle(0, "R7");
  endtask

  task automatic t_snooze;
    rd(8'h30, 0, "R8");
    cyc(1, 0, 8'h30, 4'h0, SEL, 32'h1111_1111, 0, 1, "R8 snooze");
    cyc(1, 0, 8'h31, 4'h0, SEL, 32'h2222_2222, 0, 1, "R8 snooze");
    idle(0, "R8");
    idle(0, "R8 read after release");
    cyc(1, 0, 8'h30, 4'h0, SEL, 32'h3333_3333, 0, 1, "R8 oe drops");
    idle(0, "R8 oe back");
    rd(8'h31, 0, "R8"); idle(0, "R8"); idle(0, "R8 kept 31");
    idle(0, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; snooze = 0; stall = 0; addr = 0; sel_a_n = 1; sel_b_n = 1; sel_c = 0;
    wr_n = 1; adv = 0; lane_we_n = '1; wdata = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 0;
    m_sel = 0; m_wr = 0; m_base = 0; m_cnt = 0;
    p1_v = 0; p1_w = 0; p1_a = 0; p1_b = '1; p2_v = 0; p2_w = 0; p2_a = 0; p2_b = '1;
    e_oe = 0; e_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    t_reset();
    t_back_to_back();
    t_lanes();
    t_burst();
    t_op_hold();
    t_chip_sel();
    t_stall();
    t_snooze();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule